// File: doc/BRIEF.md
# OSD pixel color decoder

The decoder turns a 5-bit on-screen-display or teletext pixel code into a
24-bit RGB pixel, eight bits per channel. One code arrives every clock (4:4:4,
one code per pixel). When bit 4 of the code is clear, the code selects a color
directly. Bits 2, 1 and 0 switch the red, green and blue primaries on or off.
Bit 3 drops every lit primary to half level. When bit 4 is set, bits 3..0
instead pick one of sixteen programmable palette entries. Each entry holds a
4-bit level for every channel.

The 4-bit channel level from either path is then scaled by one of three
contrast gains, one for each of red, green and blue. The scaled value is
clipped to the output range. The data is not filtered. A single-cycle register
write port loads the palette and the gains. Every pixel leaves the block two
clocks after it enters.

Top module: `osd_color_decoder`

## Requirements
- R1: While `rst_n` is low, all three outputs are 0. After reset every palette entry is 0 and every contrast gain is 0x44.
- R2: With code bit 4 clear and bit 3 clear, a channel whose primary bit is set (bit 2 red, bit 1 green, bit 0 blue) takes level 0xF. A channel whose bit is clear takes level 0. With the reset gains, 0xF gives 255.
- R3: With code bit 4 clear and bit 3 set, each lit primary takes level 0x7 (119 with the reset gains). Unlit channels stay 0.
- R4: With code bit 4 set, bits 3..0 index the palette. An entry stores red in bits 11..8, green in bits 7..4 and blue in bits 3..0.
- R5: A palette code read after reset produces black (0, 0, 0).
- R6: Each output equals (level × gain) >> 2, clipped to 255 when the result exceeds 8 bits.
- R7: The red, green and blue gains sit at write addresses 16, 17 and 18. Only the low 8 bits of the write data are used, and each gain affects only its own channel.
- R8: A code sampled at clock edge k appears on the outputs after edge k+1 and stays there until the next result. Codes can change on every clock.
- R9: A palette or gain write at edge k applies to every pixel sampled at edge k+1 or later. A pixel sampled at edge k still uses the previous contents.
- R10: Writes to addresses 19 through 31 change neither the palette nor the gains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_code | input | 5 | Pixel code, one per clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Write address: 0-15 palette entries, 16-18 red/green/blue gain |
| cfg_wdata | input | 12 | Write data: a palette entry, or a gain in bits 7..0 |
| osd_r | output | 8 | Red output |
| osd_g | output | 8 | Green output |
| osd_b | output | 8 | Blue output |

## Verification
The checker assumes that `pix_code` and `cfg_we` are known values on every clock edge after reset. It also assumes that the palette and the gains change only through `cfg_we`. Under those assumptions, holding the code steady with no write in between must keep the outputs steady. The bench drives all inputs at falling edges and holds defined values from time zero, so every rising edge samples settled, known data.

// File: rtl/osd_pkg.sv
package osd_pkg;

   localparam int NUM_CH = 3;

   typedef enum int {
      CH_RED   = 0,
      CH_GREEN = 1,
      CH_BLUE  = 2
   } chan_e;

   typedef enum logic {
      SRC_DIRECT  = 1'b0,
      SRC_PALETTE = 1'b1
   } src_e;

   function automatic int prim_bit(input int ch);
      return 2 - ch;
   endfunction

endpackage

// File: rtl/osd_cfg_regs.sv
module osd_cfg_regs
   import osd_pkg::*;
#(
   parameter int              LUT_DEPTH  = 16,
   parameter int              CHAN_W     = 4,
   parameter int              COEF_W     = 8,
   parameter int              ADDR_W     = 5,
   parameter int              IDX_W      = 4,
   parameter logic [COEF_W-1:0] COEF_RESET = 8'h44
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [NUM_CH*CHAN_W-1:0]    wr_data,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [NUM_CH*CHAN_W-1:0]    rd_entry,
   output logic [NUM_CH*COEF_W-1:0]    coef_all
);

   localparam int ENTRY_W = NUM_CH * CHAN_W;

   logic [ENTRY_W-1:0] pal_mem [LUT_DEPTH];
   logic               pal_hit;

   assign pal_hit = wr_en && (wr_addr < ADDR_W'(LUT_DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < LUT_DEPTH; e++) begin
            pal_mem[e] <= '0;
         end
      end else if (pal_hit) begin
         pal_mem[wr_addr[IDX_W-1:0]] <= wr_data;
      end
   end

   assign rd_entry = pal_mem[rd_idx];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_gain
         logic [COEF_W-1:0] gain_q;
         logic              gain_hit;

         assign gain_hit = wr_en && (wr_addr == ADDR_W'(LUT_DEPTH + c));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gain_q <= COEF_RESET;
            end else if (gain_hit) begin
               gain_q <= wr_data[COEF_W-1:0];
            end
         end

         assign coef_all[c*COEF_W +: COEF_W] = gain_q;
      end
   endgenerate

endmodule

// File: rtl/osd_level_stage.sv
module osd_level_stage
   import osd_pkg::*;
#(
   parameter int                CHAN_W   = 4,
   parameter int                COEF_W   = 8,
   parameter int                IDX_W    = 4,
   parameter logic [CHAN_W-1:0] FULL_LVL = 4'hF,
   parameter logic [CHAN_W-1:0] HALF_LVL = 4'h7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IDX_W:0]            pix_code,
   input  logic [NUM_CH*CHAN_W-1:0]  lut_entry,
   input  logic [NUM_CH*COEF_W-1:0]  coef_all,
   output logic [IDX_W-1:0]          rd_idx,
   output logic [NUM_CH*CHAN_W-1:0]  lvl_q,
   output logic [NUM_CH*COEF_W-1:0]  coef_q
);

   localparam int HALF_BIT = 3;

   src_e                      src_sel;
   logic                      half_sel;
   logic [NUM_CH*CHAN_W-1:0]  lvl_d;

   assign src_sel  = pix_code[IDX_W] ? SRC_PALETTE : SRC_DIRECT;
   assign half_sel = pix_code[HALF_BIT];
   assign rd_idx   = pix_code[IDX_W-1:0];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic              prim_on;
         logic [CHAN_W-1:0] dir_lvl;
         logic [CHAN_W-1:0] pal_lvl;

         assign prim_on = pix_code[prim_bit(c)];
         assign pal_lvl = lut_entry[(NUM_CH-c)*CHAN_W-1 -: CHAN_W];

         always_comb begin
            if (!prim_on) begin
               dir_lvl = '0;
            end else if (half_sel) begin
               dir_lvl = HALF_LVL;
            end else begin
               dir_lvl = FULL_LVL;
            end
         end

         assign lvl_d[c*CHAN_W +: CHAN_W] =
            (src_sel == SRC_PALETTE) ? pal_lvl : dir_lvl;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         coef_q <= '0;
      end else begin
         lvl_q  <= lvl_d;
         coef_q <= coef_all;
      end
   end

endmodule

// File: rtl/osd_gain_scale.sv
module osd_gain_scale #(
   parameter int CHAN_W   = 4,
   parameter int COEF_W   = 8,
   parameter int OUT_W    = 8,
   parameter int SHIFT    = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAN_W-1:0] lvl,
   input  logic [COEF_W-1:0] coef,
   output logic [OUT_W-1:0]  pix_q
);

   localparam int PROD_W = CHAN_W + COEF_W;
   localparam int SH_W   = PROD_W - SHIFT;

   generate
      if (SHIFT < 0 || SH_W < 1) begin : g_bad_shift
         $error("osd_gain_scale: SHIFT leaves no product bits");
      end
   endgenerate

   logic [PROD_W-1:0] prod;
   logic [OUT_W-1:0]  res;

   assign prod = PROD_W'(lvl) * PROD_W'(coef);

   generate
      if (SATURATE && (SH_W > OUT_W)) begin : g_clip
         logic [PROD_W-1:0] shifted;
         logic              ovf;

         assign shifted = prod >> SHIFT;
         assign ovf     = |shifted[PROD_W-1:OUT_W];
         assign res     = ovf ? {OUT_W{1'b1}} : shifted[OUT_W-1:0];
      end else begin : g_plain
         assign res = OUT_W'(prod >> SHIFT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= '0;
      end else begin
         pix_q <= res;
      end
   end

endmodule

// File: rtl/osd_color_decoder.sv
module osd_color_decoder
   import osd_pkg::*;
#(
   parameter int                LUT_DEPTH  = 16,
   parameter int                CHAN_W     = 4,
   parameter int                COEF_W     = 8,
   parameter int                OUT_W      = 8,
   parameter int                PROD_SHIFT = 2,
   parameter bit                SATURATE   = 1'b1,
   parameter logic [COEF_W-1:0] COEF_RESET = 8'h44,
   parameter logic [CHAN_W-1:0] FULL_LVL   = 4'hF,
   parameter logic [CHAN_W-1:0] HALF_LVL   = 4'h7,
   localparam int               IDX_W      = $clog2(LUT_DEPTH),
   localparam int               CODE_W     = IDX_W + 1,
   localparam int               ADDR_W     = $clog2(LUT_DEPTH + NUM_CH),
   localparam int               ENTRY_W    = NUM_CH * CHAN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  pix_code,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [ENTRY_W-1:0] cfg_wdata,
   output logic [OUT_W-1:0]   osd_r,
   output logic [OUT_W-1:0]   osd_g,
   output logic [OUT_W-1:0]   osd_b
);

   generate
      if (LUT_DEPTH < 16 || (LUT_DEPTH & (LUT_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("osd_color_decoder: LUT_DEPTH must be a power of two, at least 16");
      end
      if (CHAN_W < 1 || COEF_W < 1 || COEF_W > ENTRY_W) begin : g_bad_width
         $error("osd_color_decoder: gain width must fit in the write data");
      end
      if (OUT_W < 1) begin : g_bad_out
         $error("osd_color_decoder: OUT_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]          rd_idx;
   logic [ENTRY_W-1:0]        rd_entry;
   logic [NUM_CH*COEF_W-1:0]  coef_all;
   logic [ENTRY_W-1:0]        lvl_q;
   logic [NUM_CH*COEF_W-1:0]  coef_q;
   logic [NUM_CH*OUT_W-1:0]   pix_all;

   osd_cfg_regs #(
      .LUT_DEPTH  (LUT_DEPTH),
      .CHAN_W     (CHAN_W),
      .COEF_W     (COEF_W),
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .COEF_RESET (COEF_RESET)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .rd_idx   (rd_idx),
      .rd_entry (rd_entry),
      .coef_all (coef_all)
   );

   osd_level_stage #(
      .CHAN_W   (CHAN_W),
      .COEF_W   (COEF_W),
      .IDX_W    (IDX_W),
      .FULL_LVL (FULL_LVL),
      .HALF_LVL (HALF_LVL)
   ) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_code  (pix_code),
      .lut_entry (rd_entry),
      .coef_all  (coef_all),
      .rd_idx    (rd_idx),
      .lvl_q     (lvl_q),
      .coef_q    (coef_q)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_scale
         osd_gain_scale #(
            .CHAN_W   (CHAN_W),
            .COEF_W   (COEF_W),
            .OUT_W    (OUT_W),
            .SHIFT    (PROD_SHIFT),
            .SATURATE (SATURATE)
         ) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (lvl_q[c*CHAN_W +: CHAN_W]),
            .coef  (coef_q[c*COEF_W +: COEF_W]),
            .pix_q (pix_all[c*OUT_W +: OUT_W])
         );
      end
   endgenerate

   assign osd_r = pix_all[CH_RED*OUT_W   +: OUT_W];
   assign osd_g = pix_all[CH_GREEN*OUT_W +: OUT_W];
   assign osd_b = pix_all[CH_BLUE*OUT_W  +: OUT_W];

endmodule

// File: rtl/osd_color_decoder_chk.sv
module osd_color_decoder_chk #(
   parameter int CODE_W = 5,
   parameter int OUT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] pix_code,
   input logic              cfg_we,
   input logic [OUT_W-1:0]  osd_r,
   input logic [OUT_W-1:0]  osd_g,
   input logic [OUT_W-1:0]  osd_b
);

   logic [1:0] warm_cnt;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm_cnt <= '0;
      end else if (warm_cnt != 2'd3) begin
         warm_cnt <= warm_cnt + 2'd1;
      end
   end

   assign warm = (warm_cnt == 2'd3);

   // R1
   reset_black_chk: assert property (@(posedge clk)
      !rst_n |=> (osd_r == '0 && osd_g == '0 && osd_b == '0));

   // R2
   red_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_code[CODE_W-1] && !pix_code[2]) |-> ##2 (osd_r == '0));

   // R2
   green_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_code[CODE_W-1] && !pix_code[1]) |-> ##2 (osd_g == '0));

   // R2
   blue_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_code[CODE_W-1] && !pix_code[0]) |-> ##2 (osd_b == '0));

   // R8
   hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(pix_code, 2) == $past(pix_code, 3) && !$past(cfg_we, 3))
      |-> ($stable(osd_r) && $stable(osd_g) && $stable(osd_b)));

endmodule

bind osd_color_decoder osd_color_decoder_chk #(
   .CODE_W (CODE_W),
   .OUT_W  (OUT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pix_code (pix_code),
   .cfg_we   (cfg_we),
   .osd_r    (osd_r),
   .osd_g    (osd_g),
   .osd_b    (osd_b)
);

// File: tb/osd_color_decoder_test.sv
module osd_color_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  pix_code = '0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [11:0] cfg_wdata = '0;
   logic [7:0]  osd_r, osd_g, osd_b;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   osd_color_decoder uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_code  (pix_code),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .osd_r     (osd_r),
      .osd_g     (osd_g),
      .osd_b     (osd_b)
   );

   // {code, red, green, blue} with reset gains: full 255, half 119
   localparam logic [28:0] DIR_VEC [16] = '{
      {5'd0,  8'd0,   8'd0,   8'd0  },
      {5'd1,  8'd0,   8'd0,   8'd255},
      {5'd2,  8'd0,   8'd255, 8'd0  },
      {5'd3,  8'd0,   8'd255, 8'd255},
      {5'd4,  8'd255, 8'd0,   8'd0  },
      {5'd5,  8'd255, 8'd0,   8'd255},
      {5'd6,  8'd255, 8'd255, 8'd0  },
      {5'd7,  8'd255, 8'd255, 8'd255},
      {5'd8,  8'd0,   8'd0,   8'd0  },
      {5'd9,  8'd0,   8'd0,   8'd119},
      {5'd10, 8'd0,   8'd119, 8'd0  },
      {5'd11, 8'd0,   8'd119, 8'd119},
      {5'd12, 8'd119, 8'd0,   8'd0  },
      {5'd13, 8'd119, 8'd0,   8'd119},
      {5'd14, 8'd119, 8'd119, 8'd0  },
      {5'd15, 8'd119, 8'd119, 8'd119}
   };

   task automatic check_rgb(input string req, input logic [7:0] er,
                            input logic [7:0] eg, input logic [7:0] eb);
      tests++;
      if (osd_r !== er || osd_g !== eg || osd_b !== eb) begin
         fails++;
         $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d",
                  req, osd_r, osd_g, osd_b, er, eg, eb);
      end
   endtask

   task automatic show_pixel(input logic [4:0] code, input string req,
                             input logic [7:0] er, input logic [7:0] eg,
                             input logic [7:0] eb);
      @(negedge clk);
      pix_code = code;
      repeat (2) @(negedge clk);
      check_rgb(req, er, eg, eb);
   endtask

   task automatic write_reg(input logic [4:0] addr, input logic [11:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = addr;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [4:0] seq_code [4];
      logic [7:0] seq_r [4];
      logic [7:0] seq_g [4];
      logic [7:0] seq_b [4];

      // R1: outputs held at zero in reset
      repeat (3) @(negedge clk);
      check_rgb("R1 in reset", 8'd0, 8'd0, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_rgb("R1 after release", 8'd0, 8'd0, 8'd0);

      // R2 R3: direct codes with reset gains
      for (int i = 0; i < 16; i++) begin
         show_pixel(DIR_VEC[i][28:24], (i < 8) ? "R2 direct" : "R3 half",
                    DIR_VEC[i][23:16], DIR_VEC[i][15:8], DIR_VEC[i][7:0]);
      end

      // R5: palette empty after reset
      show_pixel(5'b10011, "R5 palette 3 after reset", 8'd0, 8'd0, 8'd0);
      show_pixel(5'b11111, "R5 palette 15 after reset", 8'd0, 8'd0, 8'd0);

      // R4: palette entry layout {R,G,B}
      write_reg(5'd3, 12'hF84);
      show_pixel(5'b10011, "R4 palette 3", 8'd255, 8'd136, 8'd68);

      // R6 R7: per-channel gains and clipping
      write_reg(5'd16, 12'h020);
      write_reg(5'd17, 12'h0FF);
      write_reg(5'd18, 12'h000);
      show_pixel(5'b10011, "R6 R7 palette 3 scaled", 8'd120, 8'd255, 8'd0);
      show_pixel(5'b00111, "R7 direct white scaled", 8'd120, 8'd255, 8'd0);
      show_pixel(5'b01111, "R6 half white scaled", 8'd56, 8'd255, 8'd0);

      // R9: write and pixel at the same edge
      @(negedge clk);
      pix_code  = 5'b10101;
      cfg_we    = 1'b1;
      cfg_addr  = 5'd5;
      cfg_wdata = 12'h111;
      @(negedge clk);
      cfg_we    = 1'b0;
      @(negedge clk);
      check_rgb("R9 same-edge pixel uses old entry", 8'd0, 8'd0, 8'd0);
      @(negedge clk);
      check_rgb("R9 next pixel uses new entry", 8'd8, 8'd63, 8'd0);

      // R10: unmapped addresses ignored
      write_reg(5'd18, 12'h044);
      write_reg(5'd19, 12'hFFF);
      write_reg(5'd31, 12'hFFF);
      write_reg(5'd20, 12'hFFF);
      show_pixel(5'b10011, "R10 palette 3 intact", 8'd120, 8'd255, 8'd68);
      show_pixel(5'b11111, "R10 palette 15 intact", 8'd0, 8'd0, 8'd0);
      show_pixel(5'b00111, "R10 gains intact", 8'd120, 8'd255, 8'd255);

      // R8: one code per clock, two-clock latency
      seq_code = '{5'b00001, 5'b00010, 5'b00100, 5'b01100};
      seq_r    = '{8'd0,   8'd0,   8'd120, 8'd56};
      seq_g    = '{8'd0,   8'd255, 8'd0,   8'd0};
      seq_b    = '{8'd255, 8'd0,   8'd0,   8'd0};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check_rgb("R8 streaming", seq_r[i-2], seq_g[i-2], seq_b[i-2]);
         end
         if (i < 4) begin
            pix_code = seq_code[i];
         end
      end

      // R1: reset in mid-run clears outputs, palette and gains
      @(negedge clk);
      pix_code = 5'b00111;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_rgb("R1 async reset", 8'd0, 8'd0, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      show_pixel(5'b10011, "R1 R5 palette cleared", 8'd0, 8'd0, 8'd0);
      show_pixel(5'b00111, "R1 gains restored", 8'd255, 8'd255, 8'd255);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule